// File: doc/BRIEF.md
# Readout busy-gate sequencer

This block drives the busy (inhibit) gate of one time-digitizer readout stream. A level-0 trigger arms an internal stop timer. When the common stop fires a fixed number of cycles later, the gate opens. The gate is never opened directly by the trigger. The gate then closes on the first of three events:

- a delayed copy of the trigger accept;
- a delayed copy of a fast clear (reject);
- a watchdog expiry, if no decision ever arrives.

A fast clear that comes before the common stop cannot close a gate that is not yet open. It is therefore held in a latch and replayed a fixed time after the stop. The replay takes the normal fast-clear path, so it closes the gate after its own delay.

All delays are cycle counts held as parameters. With the default 40 MHz clock they are: 10 µs stop, 12 µs accept, 400 ns clear, 250 ns replay and 50 ms watchdog. A trigger that overlaps one already in flight is dropped, and so is a decision that arrives with no trigger pending. Either case sets a sticky protocol-error flag.

Top module: `bg_busy_gate`

## Requirements
- R1: After reset, `busy_gate`, `clr_reissue`, `timeout` and `proto_err` are all 0, and the sequencer is idle.
- R2: The gate rises exactly STOP_CYC clock edges after the edge that samples `l0_trig` in idle, and never at any other time.
- R3: An accept sampled at edge a, while a trigger is in flight, closes the gate at edge a+ACC_DLY. ACC_DLY must exceed STOP_CYC, so this closure always comes after the rise.
- R4: A fast clear sampled at edge c while the gate is open closes the gate at edge c+CLR_DLY.
- R5: A fast clear sampled while waiting for the stop is handled as follows:
  - it counts as early if sampled at any edge up to and including the stop edge s;
  - it is latched, and `clr_reissue` pulses for one cycle at edge s+REPLAY_DLY;
  - the gate falls at s+REPLAY_DLY+CLR_DLY.
- R6: Only the first decision per trigger counts. If accept and fast clear arrive in the same cycle, the accept wins. Any later accept or fast clear for that trigger changes no closure time and no replay.
- R7: With no decision, the gate falls at s+TIMEOUT_CYC. `timeout` is then high for exactly the one cycle after that edge. `timeout` is not raised when a decision closes the gate at the same edge.
- R8: Two cases are ignored and set `proto_err`, which stays set until reset:
  - a `l0_trig` while a trigger is in flight;
  - an `accept` or `fast_clr` while idle.
- R9: After each closure the sequencer is idle and serves the next trigger with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l0_trig | input | 1 | Level-0 trigger pulse |
| accept | input | 1 | Trigger-accept decision pulse |
| fast_clr | input | 1 | Fast-clear (reject) decision pulse |
| busy_gate | output | 1 | Readout inhibit gate |
| clr_reissue | output | 1 | One-cycle replay of a latched early fast clear |
| timeout | output | 1 | One-cycle pulse when the watchdog closes the gate |
| proto_err | output | 1 | Sticky flag for a dropped trigger or an orphan decision |

## Verification
The hardest cases to reach are decisions that land on the cycle boundaries around the common stop:

- a fast clear sampled on the very edge where the stop fires;
- a late clear whose closure coincides with the watchdog edge.

The bench reaches both by sweeping the decision offset one cycle at a time across the whole window, from just after the trigger to just before watchdog expiry. It uses small delay parameters, so every boundary falls inside the sweep. Each offset is run once for accept and once for fast clear. The expected edges are computed arithmetically from the offset.

// File: rtl/bg_pkg.sv
package bg_pkg;
   typedef enum logic [1:0] {
      BG_IDLE = 2'd0,
      BG_WAIT = 2'd1,
      BG_OPEN = 2'd2
   } bg_state_e;
endpackage

// File: rtl/bg_delay.sv
// One-shot cycle delay: 'done' is high in the cycle before edge start+N.
module bg_delay #(
   parameter int unsigned N = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic cancel,
   output logic done
);
   localparam int unsigned W = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 1) begin : g_bad_n
         $error("bg_delay: N must be at least 1");
      end

      if (N == 1) begin : g_single
         logic act;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      act <= 1'b0;
            else if (cancel) act <= 1'b0;
            else if (start)  act <= 1'b1;
            else             act <= 1'b0;
         end
         assign done = act;
      end else begin : g_count
         logic         act;
         logic [W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act <= 1'b0;
               cnt <= '0;
            end else if (cancel) begin
               act <= 1'b0;
               cnt <= '0;
            end else if (start) begin
               act <= 1'b1;
               cnt <= '0;
            end else if (done) begin
               act <= 1'b0;
            end else if (act) begin
               cnt <= cnt + 1'b1;
            end
         end
         assign done = act && (cnt == W'(N - 1));
      end
   endgenerate
endmodule

// File: rtl/bg_clr_latch.sv
// Holds an early fast clear until it has been replayed.
module bg_clr_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic release_i,
   output logic pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend <= 1'b0;
      else if (release_i) pend <= 1'b0;
      else if (set)       pend <= 1'b1;
   end
endmodule

// File: rtl/bg_busy_gate.sv
module bg_busy_gate
   import bg_pkg::*;
#(
   parameter int unsigned STOP_CYC    = 400,
   parameter int unsigned ACC_DLY     = 480,
   parameter int unsigned CLR_DLY     = 16,
   parameter int unsigned REPLAY_DLY  = 10,
   parameter int unsigned TIMEOUT_CYC = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic l0_trig,
   input  logic accept,
   input  logic fast_clr,
   output logic busy_gate,
   output logic clr_reissue,
   output logic timeout,
   output logic proto_err
);
   generate
      if (ACC_DLY <= STOP_CYC) begin : g_bad_acc
         $error("bg_busy_gate: ACC_DLY must exceed STOP_CYC");
      end
      if (TIMEOUT_CYC <= REPLAY_DLY + CLR_DLY) begin : g_bad_to
         $error("bg_busy_gate: TIMEOUT_CYC must exceed REPLAY_DLY + CLR_DLY");
      end
   endgenerate

   bg_state_e st_q, st_d;
   logic decided_q, err_q, reissue_q, tmo_q;
   logic in_flight, l0_take, decide_ok;
   logic acc_take, clr_early, clr_late;
   logic stop_fire, acc_fire, clr_fire, rep_fire, to_fire;
   logic early_pend, close_now;

   assign in_flight = (st_q != BG_IDLE);
   assign l0_take   = l0_trig && !in_flight;
   assign decide_ok = in_flight && !decided_q;
   assign acc_take  = accept && decide_ok;
   assign clr_early = fast_clr && !accept && decide_ok && (st_q == BG_WAIT);
   assign clr_late  = fast_clr && !accept && decide_ok && (st_q == BG_OPEN);
   assign close_now = (st_q == BG_OPEN) && (acc_fire || clr_fire || to_fire);

   bg_delay #(.N(STOP_CYC)) u_stop (
      .clk(clk), .rst_n(rst_n), .start(l0_take), .cancel(1'b0), .done(stop_fire));

   bg_delay #(.N(ACC_DLY)) u_acc (
      .clk(clk), .rst_n(rst_n), .start(acc_take), .cancel(close_now), .done(acc_fire));

   bg_delay #(.N(CLR_DLY)) u_clr (
      .clk(clk), .rst_n(rst_n), .start(clr_late || rep_fire), .cancel(close_now),
      .done(clr_fire));

   bg_delay #(.N(REPLAY_DLY)) u_rep (
      .clk(clk), .rst_n(rst_n), .start(stop_fire && (early_pend || clr_early)),
      .cancel(close_now), .done(rep_fire));

   bg_delay #(.N(TIMEOUT_CYC)) u_wdog (
      .clk(clk), .rst_n(rst_n), .start(stop_fire), .cancel(close_now), .done(to_fire));

   bg_clr_latch u_early (
      .clk(clk), .rst_n(rst_n), .set(clr_early), .release_i(rep_fire || close_now),
      .pend(early_pend));

   always_comb begin
      st_d = st_q;
      case (st_q)
         BG_IDLE: if (l0_take)   st_d = BG_WAIT;
         BG_WAIT: if (stop_fire) st_d = BG_OPEN;
         BG_OPEN: if (close_now) st_d = BG_IDLE;
         default:                st_d = BG_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= BG_IDLE;
         decided_q <= 1'b0;
         err_q     <= 1'b0;
         reissue_q <= 1'b0;
         tmo_q     <= 1'b0;
      end else begin
         st_q      <= st_d;
         reissue_q <= rep_fire;
         tmo_q     <= close_now && to_fire && !acc_fire && !clr_fire;
         err_q     <= err_q || (l0_trig && in_flight)
                            || ((accept || fast_clr) && !in_flight);
         if (close_now)                            decided_q <= 1'b0;
         else if (acc_take || clr_early || clr_late) decided_q <= 1'b1;
      end
   end

   assign busy_gate   = (st_q == BG_OPEN);
   assign clr_reissue = reissue_q;
   assign timeout     = tmo_q;
   assign proto_err   = err_q;
endmodule

// File: rtl/bg_busy_gate_chk.sv
module bg_busy_gate_chk #(
   parameter int unsigned TO_CYC = 20
) (
   input logic clk,
   input logic rst_n,
   input logic gate,
   input logic stop_fire,
   input logic reissue,
   input logic tmo,
   input logic err
);
   logic [31:0] open_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    open_cnt <= '0;
      else if (gate) open_cnt <= open_cnt + 1;
      else           open_cnt <= '0;
   end

   p_rise_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate) |-> $past(stop_fire));

   p_replay_in_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reissue |-> gate);

   p_tmo_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |-> (!gate && $past(gate)));

   p_tmo_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> !tmo);

   p_width_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      gate |-> (open_cnt < TO_CYC));

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
endmodule

bind bg_busy_gate bg_busy_gate_chk #(.TO_CYC(TIMEOUT_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .gate(busy_gate), .stop_fire(stop_fire),
   .reissue(clr_reissue), .tmo(timeout), .err(proto_err));

// File: tb/bg_busy_gate_test.sv
`timescale 1ns/1ps
module bg_busy_gate_test;
   localparam int STOP = 6, ACC = 9, CLR = 3, REP = 2, TO = 20;
   localparam int S = 1 + STOP;   // relative edge of the stop for an l0 driven at step 0
   localparam int STEPS = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   logic l0_trig = 1'b0, accept = 1'b0, fast_clr = 1'b0;
   logic busy_gate, clr_reissue, timeout, proto_err;
   int n_chk = 0, n_fail = 0, cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   bg_busy_gate #(.STOP_CYC(STOP), .ACC_DLY(ACC), .CLR_DLY(CLR),
                  .REPLAY_DLY(REP), .TIMEOUT_CYC(TO)) uut (
      .clk(clk), .rst_n(rst_n), .l0_trig(l0_trig), .accept(accept),
      .fast_clr(fast_clr), .busy_gate(busy_gate), .clr_reissue(clr_reissue),
      .timeout(timeout), .proto_err(proto_err));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !finished) begin
         finished = 1;
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; l0_trig = 1'b0; accept = 1'b0; fast_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // One trigger at step 0; decision pulses at the given steps (-1 = none).
   // Records the relative edge of each observed output event (-1 = none).
   task automatic run(input int acc_i, input int clr_i, input int clr2_i, input int l0b_i,
                      output int rise, output int fall, output int rep_j,
                      output int to_j, output int err_end);
      rise = -1; fall = -1; rep_j = -1; to_j = -1;
      for (int j = 0; j <= STEPS; j++) begin
         @(negedge clk);
         if (j > 0) begin
            if (busy_gate && rise < 0) rise = j;
            if (!busy_gate && rise >= 0 && fall < 0) fall = j;
            if (clr_reissue && rep_j < 0) rep_j = j;
            if (timeout && to_j < 0) to_j = j;
         end
         l0_trig  = (j == 0) || (j == l0b_i);
         accept   = (j == acc_i);
         fast_clr = (j == clr_i) || (j == clr2_i);
      end
      err_end = proto_err;
   endtask

   initial begin
      int r, f, rp, t, e, ef, ex_to;
      do_reset();
      @(negedge clk);
      // R1: reset state
      chk("R1 gate", busy_gate, 0);
      chk("R1 reissue", clr_reissue, 0);
      chk("R1 timeout", timeout, 0);
      chk("R1 err", proto_err, 0);

      // R3 / R7 / R9: accept swept over the whole window
      for (int d = 1; d <= STOP + TO - 1; d++) begin
         run(d, -1, -1, -1, r, f, rp, t, e);
         ef = (d + 1 + ACC < S + TO) ? d + 1 + ACC : S + TO;
         ex_to = (d + 1 + ACC > S + TO) ? S + TO : -1;
         chk("R2 rise after accept trigger", r, S);
         chk("R3 accept close", f, ef);
         chk("R7 timeout vs accept", t, ex_to);
         chk("R3 no reissue", rp, -1);
         chk("R9 no err", e, 0);
      end

      // R4 / R5 / R7: fast clear swept; early when sampled at or before the stop
      for (int d = 1; d <= STOP + TO - 1; d++) begin
         run(-1, d, -1, -1, r, f, rp, t, e);
         if (d + 1 <= S) begin
            chk("R5 early close", f, S + REP + CLR);
            chk("R5 reissue edge", rp, S + REP);
            chk("R5 no timeout", t, -1);
         end else begin
            ef = (d + 1 + CLR < S + TO) ? d + 1 + CLR : S + TO;
            ex_to = (d + 1 + CLR > S + TO) ? S + TO : -1;
            chk("R4 late close", f, ef);
            chk("R4 no reissue", rp, -1);
            chk("R7 timeout vs clear", t, ex_to);
         end
         chk("R2 rise after clear trigger", r, S);
         chk("R9 no err", e, 0);
      end

      // R7: no decision at all
      run(-1, -1, -1, -1, r, f, rp, t, e);
      chk("R7 watchdog close", f, S + TO);
      chk("R7 timeout edge", t, S + TO);

      // R6: second clear after an early clear is ignored
      run(-1, 1, 10, -1, r, f, rp, t, e);
      chk("R6 second clear close", f, S + REP + CLR);
      chk("R6 second clear reissue", rp, S + REP);
      chk("R6 second clear err", e, 0);
      // R6: accept after an early clear is ignored
      run(10, 1, -1, -1, r, f, rp, t, e);
      chk("R6 late accept close", f, S + REP + CLR);
      // R6: simultaneous accept and clear, accept wins
      run(2, 2, -1, -1, r, f, rp, t, e);
      chk("R6 tie close", f, 3 + ACC);
      chk("R6 tie no reissue", rp, -1);
      // R6: clear after a late accept is ignored
      run(8, 9, -1, -1, r, f, rp, t, e);
      chk("R6 accept then clear", f, 9 + ACC);

      // R8: second trigger in flight ignored, error set
      run(4, -1, -1, 3, r, f, rp, t, e);
      chk("R8 rise from first trigger", r, S);
      chk("R8 close from accept", f, 5 + ACC);
      chk("R8 err on overlap", e, 1);

      // R8: orphan accept while idle
      do_reset();
      @(negedge clk); accept = 1'b1;
      @(negedge clk); accept = 1'b0;
      begin
         int seen = 0;
         for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            if (busy_gate) seen = 1;
         end
         chk("R8 orphan accept no gate", seen, 0);
      end
      chk("R8 orphan accept err", proto_err, 1);
      do_reset();
      @(negedge clk);
      chk("R1 err cleared by reset", proto_err, 0);

      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule